// File: doc/BRIEF.md
# Memory-Request Packet to Wishbone Bridge

This block is a simple PCIe target. It accepts memory-request transaction layer packets, one 32-bit word per beat, on a receive stream that flags the first and last beat of every packet. It decodes 3-DW-header memory reads and writes whose address falls in one fixed 256 MB window. Each payload DWORD becomes one single Wishbone master cycle with a byte address and byte selects. For a read, the block sends a completion-with-data packet back on a 32-bit transmit stream. The header goes out first, and then one data beat follows each Wishbone read.

The bridge handles one request at a time. It stops taking receive beats until the current request has finished, including the last beat of its completion. Packet data is big-endian in byte order and is swapped into the little-endian word of the internal bus in both directions. A separate small forwarder turns a level interrupt input into legacy interrupt assert and deassert requests. Each request waits for a grant.

Top module: `tlp_wb_bridge`

## Requirements
- R1: After reset, `rx_ready` is 1, and `wb_cyc`, `wb_stb`, `tx_valid` and `intx_req` are all 0.
- R2: Only packets whose first header word has bits [31:24] equal to 0x00 (memory read, 3-DW header, no data) or 0x40 (memory write, 3-DW header, with data) are served. Any other packet is consumed up to its last beat and causes no Wishbone cycle and no transmit beat.
- R3: A request is served only when address bits [31:WIN_BITS] (header word 2) equal the same bits of `BAR_BASE`. Other requests are consumed and ignored.
- R4: The length field (header word 0, bits [9:0]) must be 1 to `MAX_DW`. A request with length 0 or with more than `MAX_DW` is consumed and ignored.
- R5: Each DWORD i of a request makes exactly one Wishbone cycle. Its address is the request's DWORD address (header word 2, bits [31:2]) plus i, shifted left by 2. For i = 0, the two low bits hold the index of the lowest set bit of the first byte enable (0 when it is empty). They are 0 for every later DWORD.
- R6: Byte selects come from header word 1: first byte enable [3:0] and last byte enable [7:4]. A length-1 request uses the first field and ignores the last. A longer request uses the first field on DWORD 0, 4'hF on middle DWORDs and the last field on the final DWORD. Select bit k enables bits [8k+7:8k].
- R7: Packet byte [31:24] maps to bus byte [7:0], and so on down, in both directions.
- R8: Once `wb_stb` is high, it stays high with address, select, write flag and write data unchanged until `wb_ack`.
- R9: A read completion is three header beats and then `length` data beats. Header word 0 is {0x4A, 0, TC, 0, 0, attr, 00, length}, carrying the request's TC (bits [22:20]) and attr (bits [13:12]). Word 1 is {`cpl_id`, status 000, 0, byte count}. Word 2 is {requester ID, tag, 0, lower address} (header word 1 gives ID [31:16] and tag [15:8]). `tx_sop` marks the first beat and `tx_eop` the last.
- R10: The completion byte count is the span of enabled bytes. For length 1 it runs from the lowest to the highest set bit of the first enable, and it is 1 when that enable is empty. For length n > 1 it is 4(n-2) + (4 - lowest set index of first) + (highest set index of last + 1). The lower address is {address bits [6:2], R5 low bits}.
- R11: While a request is being served (during its Wishbone cycles and completion beats), `rx_ready` is 0.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_sop` and `tx_eop` hold.
- R13: When `irq_in` differs from the last granted level, `intx_req` rises with `intx_assert` equal to `irq_in`. Both hold until `intx_grant`, and then `intx_req` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl_id | input | 16 | Completer ID placed in completions |
| rx_data | input | 32 | Receive packet word |
| rx_sop | input | 1 | First beat of a packet |
| rx_eop | input | 1 | Last beat of a packet |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Block accepts a receive beat |
| tx_data | output | 32 | Transmit packet word |
| tx_sop | output | 1 | First transmit beat |
| tx_eop | output | 1 | Last transmit beat |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Sink accepts transmit beat |
| wb_adr | output | 32 | Wishbone byte address |
| wb_dat_o | output | 32 | Wishbone write data |
| wb_dat_i | input | 32 | Wishbone read data |
| wb_sel | output | 4 | Wishbone byte selects |
| wb_we | output | 1 | Wishbone write enable |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_ack | input | 1 | Wishbone acknowledge |
| irq_in | input | 1 | Level interrupt source |
| intx_req | output | 1 | Legacy interrupt message request |
| intx_assert | output | 1 | 1 = assert, 0 = deassert |
| intx_grant | input | 1 | Request taken |

## Verification
The bench builds the bridge with `BAR_BASE` = 0x9000_0000, the default 28-bit window and `MAX_DW` = 16. With the small length limit, both the last-DWORD boundary and the over-limit drop can be reached in short packets. Random lengths span the whole legal range, so single, two-DWORD and multi-DWORD byte-enable handling all occur, and addresses just outside the window exercise the decode. Random Wishbone acknowledge delays and transmit backpressure stress the hold rules, and two directed stalls check those rules at the ports.

// File: rtl/tlp_wb_pkg.sv
package tlp_wb_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR1, S_HDR2, S_DROP, S_WDAT, S_WBW,
    S_CH0, S_CH1, S_CH2, S_WBR, S_CDAT
  } eng_state_t;

  localparam logic [7:0] FT_MRD32 = 8'h00;
  localparam logic [7:0] FT_MWR32 = 8'h40;
  localparam logic [7:0] FT_CPLD  = 8'h4A;
  localparam int         LEN_W    = 10;

  // packet byte order <-> bus little-endian lanes
  function automatic logic [31:0] swap32(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  // offset of the first enabled byte
  function automatic logic [1:0] first_off(input logic [3:0] be);
    if (be[0]) return 2'd0;
    if (be[1]) return 2'd1;
    if (be[2]) return 2'd2;
    if (be[3]) return 2'd3;
    return 2'd0;
  endfunction

  // number of disabled bytes above the last enabled one
  function automatic logic [1:0] top_gap(input logic [3:0] be);
    if (be[3]) return 2'd0;
    if (be[2]) return 2'd1;
    if (be[1]) return 2'd2;
    if (be[0]) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [11:0] cpl_bytes(input logic [LEN_W-1:0] len,
                                            input logic [3:0] fbe,
                                            input logic [3:0] lbe);
    if (len == LEN_W'(1)) begin
      if (fbe == 4'h0) return 12'd1;
      return 12'd4 - 12'(first_off(fbe)) - 12'(top_gap(fbe));
    end
    return {len, 2'b00} - 12'(first_off(fbe)) - 12'(top_gap(lbe));
  endfunction

  function automatic logic [3:0] lane_sel(input logic [LEN_W-1:0] len,
                                          input logic [LEN_W-1:0] idx,
                                          input logic [3:0] fbe,
                                          input logic [3:0] lbe);
    if (idx == '0) return fbe;
    if (idx == len - LEN_W'(1)) return lbe;
    return 4'hF;
  endfunction

endpackage

// File: rtl/tlp_cpl_hdr.sv
module tlp_cpl_hdr
  import tlp_wb_pkg::*;
(
  input  logic [1:0]       beat,
  input  logic [LEN_W-1:0] len,
  input  logic [2:0]       tc,
  input  logic [1:0]       attr,
  input  logic [15:0]      cpl_id,
  input  logic [15:0]      req_id,
  input  logic [7:0]       tag,
  input  logic [3:0]       fbe,
  input  logic [3:0]       lbe,
  input  logic [4:0]       addr_lo,
  output logic [31:0]      hdr_dw
);
  logic [11:0] bytes;
  logic [6:0]  low_addr;

  assign bytes    = cpl_bytes(len, fbe, lbe);
  assign low_addr = {addr_lo, first_off(fbe)};

  always_comb begin
    case (beat)
      2'd0:    hdr_dw = {FT_CPLD, 1'b0, tc, 4'b0, 2'b0, attr, 2'b0, len};
      2'd1:    hdr_dw = {cpl_id, 3'b000, 1'b0, bytes};
      default: hdr_dw = {req_id, tag, 1'b0, low_addr};
    endcase
  end
endmodule

// File: rtl/tlp_req_engine.sv
module tlp_req_engine
  import tlp_wb_pkg::*;
#(
  parameter int          WIN_BITS = 28,
  parameter logic [31:0] BAR_BASE = 32'h9000_0000,
  parameter int          MAX_DW   = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpl_id,
  input  logic [31:0] rx_data,
  input  logic        rx_sop,
  input  logic        rx_eop,
  input  logic        rx_valid,
  output logic        rx_ready,
  output logic [31:0] tx_data,
  output logic        tx_sop,
  output logic        tx_eop,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [31:0] wb_adr,
  output logic [31:0] wb_dat_o,
  input  logic [31:0] wb_dat_i,
  output logic [3:0]  wb_sel,
  output logic        wb_we,
  output logic        wb_cyc,
  output logic        wb_stb,
  input  logic        wb_ack
);
  localparam int          TAG_HI  = 31 - WIN_BITS;
  localparam logic [TAG_HI:0] WIN_TAG = BAR_BASE[31:WIN_BITS];

  eng_state_t       st;
  logic [LEN_W-1:0] len, cnt;
  logic [2:0]       tc;
  logic [1:0]       attr;
  logic [15:0]      req_id;
  logic [7:0]       tag;
  logic [3:0]       fbe, lbe;
  logic [29:0]      base_dw;
  logic             is_rd;
  logic [31:0]      wdat, rdat, hdr_dw;
  logic [1:0]       hdr_beat;

  // named events for assertions and readability
  logic rx_fire, tx_fire, wb_done, last_dw, win_hit, len_ok, hdr_ok, known_ft;

  assign rx_fire  = rx_valid && rx_ready;
  assign tx_fire  = tx_valid && tx_ready;
  assign wb_done  = wb_stb && wb_ack;
  assign last_dw  = (cnt == len - LEN_W'(1));
  assign win_hit  = (rx_data[31:WIN_BITS] == WIN_TAG);
  assign len_ok   = (len != '0) && (32'(len) <= MAX_DW);
  assign hdr_ok   = win_hit && len_ok && (is_rd == rx_eop);
  assign known_ft = (rx_data[31:24] == FT_MRD32) || (rx_data[31:24] == FT_MWR32);

  assign rx_ready = (st == S_IDLE) || (st == S_HDR1) || (st == S_HDR2) ||
                    (st == S_DROP) || (st == S_WDAT);
  assign wb_cyc   = (st == S_WBW) || (st == S_WBR);
  assign wb_stb   = wb_cyc;
  assign wb_we    = (st == S_WBW);
  assign wb_adr   = {base_dw + 30'(cnt), (cnt == '0) ? first_off(fbe) : 2'b00};
  assign wb_sel   = lane_sel(len, cnt, fbe, lbe);
  assign wb_dat_o = wdat;

  assign tx_valid = (st == S_CH0) || (st == S_CH1) || (st == S_CH2) || (st == S_CDAT);
  assign tx_sop   = (st == S_CH0);
  assign tx_eop   = (st == S_CDAT) && last_dw;
  assign hdr_beat = (st == S_CH0) ? 2'd0 : (st == S_CH1) ? 2'd1 : 2'd2;
  assign tx_data  = (st == S_CDAT) ? rdat : hdr_dw;

  tlp_cpl_hdr u_hdr (
    .beat(hdr_beat), .len(len), .tc(tc), .attr(attr), .cpl_id(cpl_id),
    .req_id(req_id), .tag(tag), .fbe(fbe), .lbe(lbe),
    .addr_lo(base_dw[4:0]), .hdr_dw(hdr_dw)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; len <= '0; cnt <= '0; tc <= '0; attr <= '0;
      req_id <= '0; tag <= '0; fbe <= '0; lbe <= '0; base_dw <= '0;
      is_rd <= 1'b0; wdat <= '0; rdat <= '0;
    end else begin
      case (st)
        S_IDLE: if (rx_fire && rx_sop) begin
          len   <= rx_data[LEN_W-1:0];
          tc    <= rx_data[22:20];
          attr  <= rx_data[13:12];
          is_rd <= (rx_data[31:24] == FT_MRD32);
          if (known_ft)     st <= S_HDR1;
          else if (!rx_eop) st <= S_DROP;
        end
        S_HDR1: if (rx_fire) begin
          req_id <= rx_data[31:16];
          tag    <= rx_data[15:8];
          lbe    <= rx_data[7:4];
          fbe    <= rx_data[3:0];
          st     <= rx_eop ? S_IDLE : S_HDR2;
        end
        S_HDR2: if (rx_fire) begin
          base_dw <= rx_data[31:2];
          cnt     <= '0;
          if (hdr_ok)      st <= is_rd ? S_CH0 : S_WDAT;
          else if (rx_eop) st <= S_IDLE;
          else             st <= S_DROP;
        end
        S_DROP: if (rx_fire && rx_eop) st <= S_IDLE;
        S_WDAT: if (rx_fire) begin
          wdat <= swap32(rx_data);
          st   <= S_WBW;
        end
        S_WBW: if (wb_done) begin
          if (last_dw) st <= S_IDLE;
          else begin cnt <= cnt + LEN_W'(1); st <= S_WDAT; end
        end
        S_CH0: if (tx_fire) st <= S_CH1;
        S_CH1: if (tx_fire) st <= S_CH2;
        S_CH2: if (tx_fire) st <= S_WBR;
        S_WBR: if (wb_done) begin
          rdat <= swap32(wb_dat_i);
          st   <= S_CDAT;
        end
        S_CDAT: if (tx_fire) begin
          if (last_dw) st <= S_IDLE;
          else begin cnt <= cnt + LEN_W'(1); st <= S_WBR; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb && !wb_ack |=> wb_stb && $stable(wb_adr) && $stable(wb_sel) &&
                          $stable(wb_we) && $stable(wb_dat_o));

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) &&
                              $stable(tx_sop) && $stable(tx_eop));

  // R11
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid || wb_cyc) |-> !rx_ready);

  // R9
  sop_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_sop, tx_eop}) && (!(tx_sop || tx_eop) || tx_valid));

endmodule

// File: rtl/tlp_intx_fwd.sv
module tlp_intx_fwd (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_in,
  output logic intx_req,
  output logic intx_assert,
  input  logic intx_grant
);
  logic granted_lvl;
  logic level_change;

  assign level_change = (irq_in != granted_lvl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intx_req    <= 1'b0;
      intx_assert <= 1'b0;
      granted_lvl <= 1'b0;
    end else if (intx_req) begin
      if (intx_grant) begin
        intx_req    <= 1'b0;
        granted_lvl <= intx_assert;
      end
    end else if (level_change) begin
      intx_req    <= 1'b1;
      intx_assert <= irq_in;
    end
  end

  // R13
  intx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intx_req && !intx_grant |=> intx_req && $stable(intx_assert));

endmodule

// File: rtl/tlp_wb_bridge.sv
module tlp_wb_bridge #(
  parameter int          WIN_BITS = 28,
  parameter logic [31:0] BAR_BASE = 32'h9000_0000,
  parameter int          MAX_DW   = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpl_id,
  input  logic [31:0] rx_data,
  input  logic        rx_sop,
  input  logic        rx_eop,
  input  logic        rx_valid,
  output logic        rx_ready,
  output logic [31:0] tx_data,
  output logic        tx_sop,
  output logic        tx_eop,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [31:0] wb_adr,
  output logic [31:0] wb_dat_o,
  input  logic [31:0] wb_dat_i,
  output logic [3:0]  wb_sel,
  output logic        wb_we,
  output logic        wb_cyc,
  output logic        wb_stb,
  input  logic        wb_ack,
  input  logic        irq_in,
  output logic        intx_req,
  output logic        intx_assert,
  input  logic        intx_grant
);
  tlp_req_engine #(.WIN_BITS(WIN_BITS), .BAR_BASE(BAR_BASE), .MAX_DW(MAX_DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .cpl_id(cpl_id),
    .rx_data(rx_data), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_valid(rx_valid),
    .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_valid(tx_valid),
    .tx_ready(tx_ready),
    .wb_adr(wb_adr), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_sel(wb_sel),
    .wb_we(wb_we), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_ack(wb_ack)
  );

  tlp_intx_fwd u_intx (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .intx_req(intx_req),
    .intx_assert(intx_assert), .intx_grant(intx_grant)
  );
endmodule

// File: tb/tlp_wb_bridge_tb.sv
`timescale 1ns/1ps
module tlp_wb_bridge_tb;
  localparam logic [31:0] BASE = 32'h9000_0000;
  localparam int MAXD = 16;

  logic clk = 0, rst_n = 0;
  logic [15:0] cpl_id = 16'hC0DE;
  logic [31:0] rx_data = 0; logic rx_sop = 0, rx_eop = 0, rx_valid = 0, rx_ready;
  logic [31:0] tx_data; logic tx_sop, tx_eop, tx_valid, tx_ready = 0;
  logic [31:0] wb_adr, wb_dat_o, wb_dat_i; logic [3:0] wb_sel;
  logic wb_we, wb_cyc, wb_stb, wb_ack = 0;
  logic irq_in = 0, intx_req, intx_assert, intx_grant = 0;

  int checks = 0, fails = 0;
  bit done = 0, tx_hold = 0, wb_stall = 0;

  always #2.5 clk = ~clk;

  tlp_wb_bridge #(.WIN_BITS(28), .BAR_BASE(BASE), .MAX_DW(MAXD)) u_dut (.*);

  function automatic logic [31:0] rd_model(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1234_5678;
  endfunction
  assign wb_dat_i = rd_model(wb_adr);

  // logs
  logic [31:0] wl_adr[64], wl_dat[64]; logic [3:0] wl_sel[64]; logic wl_we[64]; int wn = 0;
  logic [31:0] tl_dat[64]; logic tl_sop[64], tl_eop[64]; int tn = 0;

  always @(posedge clk) begin
    if (!rst_n) wb_ack <= 0;
    else begin
      wb_ack <= wb_cyc && wb_stb && !wb_ack && !wb_stall && ($urandom % 3 != 0);
      if (wb_cyc && wb_stb && wb_ack && wn < 64) begin
        wl_adr[wn] <= wb_adr; wl_sel[wn] <= wb_sel; wl_we[wn] <= wb_we;
        wl_dat[wn] <= wb_we ? wb_dat_o : wb_dat_i; wn <= wn + 1;
      end
      if (tx_valid && tx_ready && tn < 64) begin
        tl_dat[tn] <= tx_data; tl_sop[tn] <= tx_sop; tl_eop[tn] <= tx_eop; tn <= tn + 1;
      end
    end
  end
  always @(negedge clk) tx_ready <= tx_hold ? 1'b0 : ($urandom % 4 != 0);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] b_swap(input logic [31:0] d);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = d[8*(3-k) +: 8];
    return r;
  endfunction
  function automatic int b_lo(input logic [3:0] be);
    for (int k = 0; k < 4; k++) if (be[k]) return k;
    return 0;
  endfunction
  function automatic int b_hi(input logic [3:0] be);
    for (int k = 3; k >= 0; k--) if (be[k]) return k;
    return 3;
  endfunction
  function automatic int b_bytes(input int n, input logic [3:0] f, input logic [3:0] l);
    if (n == 1) return (f == 0) ? 1 : b_hi(f) - b_lo(f) + 1;
    return 4 * (n - 2) + (4 - b_lo(f)) + (b_hi(l) + 1);
  endfunction

  logic [31:0] pkt[32];
  logic [31:0] pay[32];

  task automatic send(input int n);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_data = pkt[i]; rx_sop = (i == 0); rx_eop = (i == n - 1);
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 0; rx_sop = 0; rx_eop = 0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (!(rx_ready && !wb_cyc && !tx_valid) && t < 3000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic do_req(input bit rd, input logic [7:0] ft, input logic [31:0] addr,
                        input int len, input logic [3:0] fbe, input logic [3:0] lbe,
                        input string rq);
    logic [2:0] tc = 3'($urandom); logic [1:0] at = 2'($urandom);
    logic [15:0] rid = 16'($urandom); logic [7:0] tg = 8'($urandom);
    bit acc; int nb;
    acc = (addr[31:28] == BASE[31:28]) && len >= 1 && len <= MAXD &&
          (ft == 8'h00 || ft == 8'h40);
    pkt[0] = {ft, 1'b0, tc, 4'b0, 2'b0, at, 2'b0, 10'(len)};
    pkt[1] = {rid, tg, lbe, fbe};
    pkt[2] = {addr[31:2], 2'b00};
    nb = 3;
    if (!rd) begin
      for (int i = 0; i < ((len == 0) ? 1 : len); i++) begin
        pay[i] = $urandom; pkt[3 + i] = pay[i]; nb++;
      end
    end
    wn = 0; tn = 0;
    send(nb);
    wait_idle();
    if (!acc) begin
      chk({rq, " no wb cycle"}, wn, 0);
      chk({rq, " no tx beat"}, tn, 0);
      return;
    end
    chk("R5 wb cycle count", wn, len);
    for (int i = 0; i < len && i < 64; i++) begin
      logic [31:0] ea; logic [3:0] es;
      ea = {addr[31:2] + 30'(i), (i == 0) ? 2'(b_lo(fbe)) : 2'b00};
      es = (len == 1) ? fbe : (i == 0) ? fbe : (i == len - 1) ? lbe : 4'hF;
      chk("R5 address", wl_adr[i], ea);
      chk("R6 byte select", {28'b0, wl_sel[i]}, {28'b0, es});
      chk("R2 write flag", {31'b0, wl_we[i]}, {31'b0, !rd});
      if (!rd) chk("R7 write data swap", wl_dat[i], b_swap(pay[i]));
    end
    if (rd) begin
      logic [11:0] bc = 12'(b_bytes(len, fbe, lbe));
      chk("R9 completion beats", tn, 3 + len);
      chk("R9 hdr0", tl_dat[0], {8'h4A, 1'b0, tc, 4'b0, 2'b0, at, 2'b0, 10'(len)});
      chk("R10 hdr1 byte count", tl_dat[1], {cpl_id, 4'b0, bc});
      chk("R10 hdr2 lower addr", tl_dat[2], {rid, tg, 1'b0, addr[6:2], 2'(b_lo(fbe))});
      chk("R9 sop", {tl_sop[0], tl_eop[0]}, 2'b10);
      for (int i = 0; i < len; i++) begin
        logic [31:0] ea = {addr[31:2] + 30'(i), (i == 0) ? 2'(b_lo(fbe)) : 2'b00};
        chk("R7 read data swap", tl_dat[3 + i], b_swap(rd_model(ea)));
        chk("R9 eop", {31'b0, tl_eop[3 + i]}, {31'b0, i == len - 1});
      end
    end
  endtask

  initial begin
    void'($urandom(32'd11));
    repeat (4) @(negedge clk);
    chk("R1 rx_ready", rx_ready, 1);
    chk("R1 idle outputs", {wb_cyc, wb_stb, tx_valid, intx_req}, 0);
    rst_n = 1;
    @(negedge clk);

    // directed
    do_req(0, 8'h40, BASE + 32'h100, 1, 4'b0011, 4'b1111, "R6");
    do_req(0, 8'h40, BASE + 32'h200, 3, 4'b1110, 4'b0111, "R5");
    do_req(1, 8'h00, BASE + 32'h34, 1, 4'b0100, 4'b1111, "R10");
    do_req(1, 8'h00, BASE + 32'h48, 2, 4'b1100, 4'b0011, "R10");
    do_req(1, 8'h00, BASE + 32'h50, 1, 4'b0000, 4'b0000, "R10");
    do_req(1, 8'h00, BASE + 32'h60, MAXD, 4'b1000, 4'b0001, "R4");
    do_req(0, 8'h40, 32'h8FFF_FFF0, 1, 4'hF, 4'hF, "R3 below window");
    do_req(1, 8'h00, 32'hA000_0000, 2, 4'hF, 4'hF, "R3 above window");
    do_req(0, 8'h40, BASE, MAXD + 1, 4'hF, 4'hF, "R4 too long");
    do_req(1, 8'h00, BASE, 0, 4'hF, 4'hF, "R4 zero length");
    do_req(1, 8'h20, BASE, 1, 4'hF, 4'hF, "R2 unknown type");
    do_req(0, 8'h4A, BASE, 2, 4'hF, 4'hF, "R2 completion in");

    // R8 and R11: stalled write
    wb_stall = 1;
    pkt[0] = {8'h40, 14'b0, 10'd1}; pkt[1] = {16'h1, 8'h2, 4'hF, 4'hF};
    pkt[2] = BASE + 32'h400; pkt[3] = 32'hAABBCCDD;
    wn = 0;
    send(4);
    begin
      logic [31:0] a0, d0;
      while (!wb_stb) @(negedge clk);
      a0 = wb_adr; d0 = wb_dat_o;
      repeat (4) @(negedge clk);
      chk("R8 strobe held", {31'b0, wb_stb}, 1);
      chk("R8 address held", wb_adr, a0);
      chk("R8 data held", wb_dat_o, d0);
      chk("R11 rx_ready low during write", {31'b0, rx_ready}, 0);
    end
    wb_stall = 0;
    wait_idle();

    // R12 and R11: stalled completion
    tx_hold = 1;
    pkt[0] = {8'h00, 14'b0, 10'd1}; pkt[1] = {16'h7, 8'h9, 4'h0, 4'hF};
    pkt[2] = BASE + 32'h500;
    tn = 0;
    send(3);
    begin
      logic [31:0] t0;
      repeat (2) @(negedge clk);
      while (!tx_valid) @(negedge clk);
      t0 = tx_data;
      repeat (4) @(negedge clk);
      chk("R12 valid held", {31'b0, tx_valid}, 1);
      chk("R12 data held", tx_data, t0);
      chk("R11 rx_ready low during completion", {31'b0, rx_ready}, 0);
    end
    tx_hold = 0;
    wait_idle();

    // random mix
    for (int it = 0; it < 40; it++) begin
      bit rd = $urandom % 2;
      int len = 1 + ($urandom % MAXD);
      logic [31:0] ad = BASE | (32'($urandom) & 32'h0FFF_FFFC);
      logic [3:0] f = 4'($urandom | 1), l = 4'($urandom | 8);
      if (it % 9 == 4) ad = 32'($urandom) | 32'hC000_0000;
      do_req(rd, rd ? 8'h00 : 8'h40, ad, len, f, l, "R3 random");
    end

    // R13 interrupt
    @(negedge clk) irq_in = 1;
    @(negedge clk); @(negedge clk);
    chk("R13 assert request", {intx_req, intx_assert}, 2'b11);
    repeat (3) @(negedge clk);
    chk("R13 held without grant", {intx_req, intx_assert}, 2'b11);
    intx_grant = 1; @(negedge clk); intx_grant = 0;
    @(negedge clk);
    chk("R13 drop after grant", {31'b0, intx_req}, 0);
    irq_in = 0;
    @(negedge clk); @(negedge clk);
    chk("R13 deassert request", {intx_req, intx_assert}, 2'b10);
    intx_grant = 1; @(negedge clk); intx_grant = 0;
    repeat (2) @(negedge clk);
    chk("R13 quiet after deassert", {31'b0, intx_req}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule